// File: doc/BRIEF.md
# Dual-Rail Power-Good Delay Sequencer

This block produces the active-low power-on-reset output for a pair of step-down rails. Each rail supplies an enable and two comparator flags. One flag says the output is above the upper threshold, about 91 % of target. The other says it is below the lower threshold, about 82 %. Each rail keeps a hysteretic ready bit built from these two flags. When an enabled rail becomes ready, a delay timer starts, and the reset output is held low until that delay has run out. The delay is one of four lengths, chosen by a 2-bit select.

The sequencer is a four-state machine. The states are `S_OFF` (no rail enabled), `S_ARM` (waiting for a rail to become good), `S_DELAY` (counting the selected delay) and `S_GOOD` (output released high). The transitions are:

- OFF→ARM or ARM stays: an enable is high but no trigger.
- OFF/ARM→DELAY: trigger.
- DELAY→GOOD: the delay is done and every enabled rail is ready.
- DELAY→ARM: the delay is done but an enabled rail is not ready.
- GOOD→DELAY: violation. An enabled, unexcused rail is not ready.
- any→OFF: both enables are low.

A rail whose enable rises while the output is released gets a mask window. During the window that rail's readiness is not judged. After it, the rail is judged like any other. Every timer length is a parameter in clock cycles. The defaults assume a 50 MHz clock: 50 µs, 50 ms, 100 ms and 200 ms for the delay, and 5 ms for the mask.

Top module: `pgood_delay_seq`

## Requirements
- R1: A rail's ready bit clears on a clock edge where its below-low flag is 1. It sets where its above-high flag is 1 and the below-low flag is 0. Otherwise it holds. It is 0 after reset.
- R2: The delay length is sampled when the delay starts. `dly_sel` 2'b00 gives DLY_DEF (default, 50 ms). 2'b01 gives DLY_SHORT (50 µs). 2'b10 gives DLY_MID (100 ms). 2'b11 gives DLY_LONG (200 ms).
- R3: In OFF or ARM, a rising edge of (enable AND ready) on either rail starts a delay of N cycles. `por_n` stays 0 during the delay and becomes 1 on the Nth edge after the trigger edge.
- R4: While a delay runs, ready or enable events on either rail do not restart or lengthen it.
- R5: If the delay ends while an enabled rail is not ready, `por_n` stays 0 and the sequencer waits for a new trigger.
- R6: With `por_n` at 1, an enabled, unexcused rail that is not ready drives `por_n` to 0 on the next edge and restarts the delay.
- R7: An enable rising edge sampled while `por_n` is 1 excuses that rail for MASK_CYC edges, starting with the sampling edge. `por_n` holds 1 during that time. On the following edge the rail is judged as in R6.
- R8: After reset, and on any edge with both enables 0, `por_n` is 0 from that edge on.
- R9: A rail whose enable is 0 takes no part: its flags neither trigger a delay nor pull `por_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous chip reset, active low |
| en_r0 | input | 1 | Rail 0 enable |
| hi_r0 | input | 1 | Rail 0 output above upper threshold |
| lo_r0 | input | 1 | Rail 0 output below lower threshold |
| en_r1 | input | 1 | Rail 1 enable |
| hi_r1 | input | 1 | Rail 1 output above upper threshold |
| lo_r1 | input | 1 | Rail 1 output below lower threshold |
| dly_sel | input | 2 | Delay length select (see R2) |
| por_n | output | 1 | Reset output, 0 = pull the open-drain line low |

## Verification
An above-high flag first presented before edge E sets ready at E and triggers at E+1. `por_n` then rises at E+1+N. A below-low flag sampled at E drops `por_n` at E+1. A late enable sampled at E holds `por_n` high through E+MASK_CYC−1, and it falls at E+MASK_CYC if that rail is not ready. Both enables low drops `por_n` on the same edge. The bench drives inputs on falling edges and compares `por_n` on every falling edge against a behavioural model that advances on rising edges. Its directed checks are placed at exactly these edge counts, one cycle before and one cycle on each due edge.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;

    typedef enum logic [1:0] {
        S_OFF   = 2'd0,
        S_ARM   = 2'd1,
        S_DELAY = 2'd2,
        S_GOOD  = 2'd3
    } seq_state_t;

    localparam int RAILS = 2;

endpackage

// File: rtl/pgseq_rail.sv
module pgseq_rail #(
    parameter int MASK_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic above_hi,
    input  logic below_lo,
    input  logic in_good,
    output logic ready,
    output logic active,
    output logic active_rise,
    output logic excused
);

    localparam int MW = $clog2(MASK_CYC + 1);

    logic          rdy_q;
    logic          act_prev;
    logic          en_prev;
    logic          en_rise;
    logic [MW-1:0] mask_cnt;

    assign ready       = rdy_q;
    assign active      = en & rdy_q;
    assign active_rise = active & ~act_prev;
    assign en_rise     = in_good & en & ~en_prev;
    assign excused     = en_rise | (mask_cnt != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q    <= 1'b0;
            act_prev <= 1'b0;
            en_prev  <= 1'b0;
            mask_cnt <= '0;
        end else begin
            // hysteresis: lower threshold wins, otherwise hold
            if (below_lo)
                rdy_q <= 1'b0;
            else if (above_hi)
                rdy_q <= 1'b1;
            act_prev <= active;
            en_prev  <= en;
            if (en_rise)
                mask_cnt <= MW'(MASK_CYC - 1);
            else if (!in_good)
                mask_cnt <= '0;
            else if (mask_cnt != '0)
                mask_cnt <= mask_cnt - 1'b1;
        end
    end

    p_ready_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_q) |-> $past(below_lo));

    p_ready_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_q) |-> ($past(above_hi) && !$past(below_lo)));

    p_mask_in_good_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_cnt != '0) |-> $past(in_good));

endmodule

// File: rtl/pgseq_delay.sv
module pgseq_delay #(
    parameter int DLY_DEF   = 2500000,
    parameter int DLY_SHORT = 2500,
    parameter int DLY_MID   = 5000000,
    parameter int DLY_LONG  = 10000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] sel,
    input  logic       run,
    output logic       done
);

    localparam int MAX_AB = (DLY_DEF > DLY_SHORT) ? DLY_DEF : DLY_SHORT;
    localparam int MAX_CD = (DLY_MID > DLY_LONG) ? DLY_MID : DLY_LONG;
    localparam int MAXV   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CW     = $clog2(MAXV + 1);

    logic [CW-1:0] cnt;

    function automatic logic [CW-1:0] span_m1(input logic [1:0] s);
        logic [CW-1:0] v;
        unique case (s)
            2'b00: v = CW'(DLY_DEF - 1);
            2'b01: v = CW'(DLY_SHORT - 1);
            2'b10: v = CW'(DLY_MID - 1);
            2'b11: v = CW'(DLY_LONG - 1);
        endcase
        return v;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= span_m1(sel);
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/pgood_delay_seq.sv
module pgood_delay_seq
    import pgseq_pkg::*;
#(
    parameter int DLY_DEF   = 2500000,
    parameter int DLY_SHORT = 2500,
    parameter int DLY_MID   = 5000000,
    parameter int DLY_LONG  = 10000000,
    parameter int MASK_CYC  = 250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_r0,
    input  logic       hi_r0,
    input  logic       lo_r0,
    input  logic       en_r1,
    input  logic       hi_r1,
    input  logic       lo_r1,
    input  logic [1:0] dly_sel,
    output logic       por_n
);

    seq_state_t st, st_nxt;

    logic [RAILS-1:0] en_v, hi_v, lo_v;
    logic [RAILS-1:0] rdy_v, act_v, rise_v, exc_v;
    logic             in_good;
    logic             any_en, all_ok, trig, viol;
    logic             dly_load, dly_done;

    assign en_v    = {en_r1, en_r0};
    assign hi_v    = {hi_r1, hi_r0};
    assign lo_v    = {lo_r1, lo_r0};
    assign in_good = (st == S_GOOD);

    for (genvar i = 0; i < RAILS; i++) begin : g_rail
        pgseq_rail #(.MASK_CYC(MASK_CYC)) u_rail (
            .clk         (clk),
            .rst_n       (rst_n),
            .en          (en_v[i]),
            .above_hi    (hi_v[i]),
            .below_lo    (lo_v[i]),
            .in_good     (in_good),
            .ready       (rdy_v[i]),
            .active      (act_v[i]),
            .active_rise (rise_v[i]),
            .excused     (exc_v[i])
        );
    end

    assign any_en = |en_v;
    assign all_ok = any_en & (&(~en_v | rdy_v));
    assign trig   = |rise_v;
    assign viol   = |(en_v & ~rdy_v & ~exc_v);

    // next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            S_OFF, S_ARM: begin
                if (!any_en)      st_nxt = S_OFF;
                else if (trig)    st_nxt = S_DELAY;
                else              st_nxt = S_ARM;
            end
            S_DELAY: begin
                if (!any_en)      st_nxt = S_OFF;
                else if (dly_done) st_nxt = all_ok ? S_GOOD : S_ARM;
            end
            S_GOOD: begin
                if (!any_en)      st_nxt = S_OFF;
                else if (viol)    st_nxt = S_DELAY;
            end
        endcase
    end

    assign dly_load = (st != S_DELAY) && (st_nxt == S_DELAY);

    pgseq_delay #(
        .DLY_DEF   (DLY_DEF),
        .DLY_SHORT (DLY_SHORT),
        .DLY_MID   (DLY_MID),
        .DLY_LONG  (DLY_LONG)
    ) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (dly_load),
        .sel   (dly_sel),
        .run   (st == S_DELAY),
        .done  (dly_done)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= S_OFF;
        else
            st <= st_nxt;
    end

    // outputs
    always_comb begin
        por_n = (st == S_GOOD);
    end

    p_rise_after_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(por_n) |-> ($past(st) == S_DELAY && $past(dly_done)));

    p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DELAY && !dly_done && any_en) |=> (st == S_DELAY && !por_n));

    p_incomplete_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DELAY && dly_done && !all_ok) |=> !por_n);

    p_drop_restarts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (por_n && any_en && (|(en_v & ~rdy_v & ~exc_v))) |=> (st == S_DELAY));

    p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_r0 && !en_r1) |=> !por_n);

endmodule

// File: tb/tb_pgood_delay_seq.sv
module tb_pgood_delay_seq;

    localparam int T_DEF   = 10;
    localparam int T_SHORT = 3;
    localparam int T_MID   = 20;
    localparam int T_LONG  = 40;
    localparam int T_MASK  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en0 = 1'b0, hi0 = 1'b0, lo0 = 1'b1;
    logic       en1 = 1'b0, hi1 = 1'b0, lo1 = 1'b1;
    logic [1:0] sel = 2'b00;
    logic       por_n;

    int    n_chk  = 0;
    int    n_fail = 0;
    string tag    = "R8";
    bit    live   = 1'b0;

    always #10 clk = ~clk;

    pgood_delay_seq #(
        .DLY_DEF(T_DEF), .DLY_SHORT(T_SHORT), .DLY_MID(T_MID),
        .DLY_LONG(T_LONG), .MASK_CYC(T_MASK)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .en_r0(en0), .hi_r0(hi0), .lo_r0(lo0),
        .en_r1(en1), .hi_r1(hi1), .lo_r1(lo1),
        .dly_sel(sel), .por_n(por_n)
    );

    // behavioural reference: mode 0 off, 1 waiting, 2 counting, 3 released
    int m_mode = 0;
    int m_left = 0;
    bit m_rdy[2];
    bit m_was_good[2];
    bit m_en_was[2];
    int m_mask[2];

    function automatic int span(input logic [1:0] s);
        case (s)
            2'b00:   return T_DEF;
            2'b01:   return T_SHORT;
            2'b10:   return T_MID;
            default: return T_LONG;
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit e[2], h[2], l[2], g[2], up[2], late[2], exc[2];
        bit any, fine, bad, start;
        int nxt;
        e[0] = en0; h[0] = hi0; l[0] = lo0;
        e[1] = en1; h[1] = hi1; l[1] = lo1;
        if (!rst_n) begin
            m_mode = 0; m_left = 0;
            for (int i = 0; i < 2; i++) begin
                m_rdy[i] = 0; m_was_good[i] = 0; m_en_was[i] = 0; m_mask[i] = 0;
            end
        end else begin
            any = e[0] || e[1];
            fine = any; bad = 0; start = 0;
            for (int i = 0; i < 2; i++) begin
                g[i]    = e[i] && m_rdy[i];
                up[i]   = g[i] && !m_was_good[i];
                late[i] = (m_mode == 3) && e[i] && !m_en_was[i];
                exc[i]  = late[i] || (m_mask[i] > 0);
                if (e[i] && !m_rdy[i]) fine = 0;
                if (e[i] && !m_rdy[i] && !exc[i]) bad = 1;
                if (up[i]) start = 1;
            end
            nxt = m_mode;
            if (!any) nxt = 0;
            else if (m_mode <= 1) nxt = start ? 2 : 1;
            else if (m_mode == 2) begin
                if (m_left == 0) nxt = fine ? 3 : 1;
            end else if (bad) nxt = 2;
            if (nxt == 2 && m_mode != 2) m_left = span(sel) - 1;
            else if (m_mode == 2 && m_left > 0) m_left--;
            for (int i = 0; i < 2; i++) begin
                if (late[i]) m_mask[i] = T_MASK - 1;
                else if (m_mode != 3) m_mask[i] = 0;
                else if (m_mask[i] > 0) m_mask[i]--;
                if (l[i]) m_rdy[i] = 0;
                else if (h[i]) m_rdy[i] = 1;
                m_was_good[i] = g[i];
                m_en_was[i] = e[i];
            end
            m_mode = nxt;
        end
        live = 1'b1;
    end

    always @(negedge clk) begin
        if (live) begin
            n_chk++;
            if (por_n !== (m_mode == 3)) begin
                n_fail++;
                $display("FAIL %s per-cycle compare: por_n actual=%b expected=%b at %0t",
                         tag, por_n, (m_mode == 3), $time);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic exp);
        n_chk++;
        if (por_n !== exp) begin
            n_fail++;
            $display("FAIL %s directed: por_n actual=%b expected=%b at %0t",
                     req, por_n, exp, $time);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin : stim
        cyc(4);
        tag = "R8"; chk("R8", 1'b0);
        rst_n = 1'b1;
        cyc(2);
        // both enabled, neither ready yet
        tag = "R3"; en0 = 1; en1 = 1;
        cyc(3); chk("R3", 1'b0);
        hi0 = 1; lo0 = 0; hi1 = 1; lo1 = 0;
        cyc(T_DEF + 1); chk("R3", 1'b0);
        cyc(1); chk("R3", 1'b1);
        // flags idle between thresholds: ready holds
        tag = "R1"; hi0 = 0; hi1 = 0;
        cyc(5); chk("R1", 1'b1);
        // rail 1 dips below lower threshold
        tag = "R6"; lo1 = 1;
        cyc(1); lo1 = 0; chk("R6", 1'b1);
        cyc(1); chk("R6", 1'b0);
        tag = "R5";
        cyc(T_DEF); chk("R5", 1'b0);
        cyc(3); chk("R5", 1'b0);
        // rail 1 recovers, short delay
        tag = "R2"; sel = 2'b01; hi1 = 1;
        cyc(T_SHORT + 1); hi1 = 0; chk("R2", 1'b0);
        cyc(1); chk("R2", 1'b1);
        // events during a running delay
        tag = "R4"; sel = 2'b10; lo0 = 1;
        cyc(1); lo0 = 0;
        cyc(1); chk("R4", 1'b0); hi0 = 1;
        cyc(1); hi0 = 0; en1 = 0;
        cyc(2); en1 = 1;
        cyc(T_MID - 4); chk("R4", 1'b0);
        cyc(1); chk("R4", 1'b1);
        // longest delay
        tag = "R2"; sel = 2'b11; lo0 = 1;
        cyc(1); lo0 = 0; hi0 = 1;
        cyc(1); hi0 = 0;
        cyc(T_LONG - 1); chk("R2", 1'b0);
        cyc(1); chk("R2", 1'b1);
        sel = 2'b00;
        // rail 1 disabled and sagging: no effect
        tag = "R9"; en1 = 0; lo1 = 1;
        cyc(6); chk("R9", 1'b1);
        lo1 = 0;
        // late enable of a rail that is not ready
        tag = "R7"; en1 = 1;
        cyc(T_MASK); chk("R7", 1'b1);
        cyc(1); chk("R7", 1'b0);
        cyc(T_DEF + 2); hi1 = 1;
        cyc(1); hi1 = 0;
        cyc(T_DEF + 3); chk("R7", 1'b1);
        // late enable of a ready rail keeps output high
        en1 = 0; cyc(2); en1 = 1;
        cyc(T_MASK + 3); chk("R7", 1'b1);
        // both enables low
        tag = "R8"; en0 = 0; en1 = 0;
        cyc(1); chk("R8", 1'b0);
        // single rail only, other rail flags toggling
        tag = "R9"; en0 = 1; hi1 = 1; lo1 = 0;
        cyc(2); hi1 = 0; lo1 = 1;
        cyc(T_DEF + 3); chk("R9", 1'b1);
        lo1 = 0; hi1 = 1;
        cyc(3); chk("R9", 1'b1);
        hi1 = 0;
        cyc(2);
        summary();
        $finish;
    end

endmodule